// File: doc/BRIEF.md
# Sequential Signed/Unsigned Shift-Add Multiplier

This block multiplies two `WIDTH`-bit operands over `WIDTH` clock cycles, adding at most one partial product per cycle. A running accumulator and a multiplier register together form one double-width register. After every add it shifts right by one bit. The multiplier bits are used up from the bottom, and the low half of the product collects where they were. The block needs one adder of `WIDTH+1` bits plus three operand-sized registers, whatever the operand width.

A mode pin chooses unsigned or two's-complement operation. In signed mode the accumulator is sign-extended into the adder and on every shift. The partial product for the multiplier's top bit is subtracted, because that bit carries negative weight. The control pins are plain level/pulse signals. A `start` pulse is accepted only while `busy` is low, so `!busy` plays the role of a ready signal. No back-pressure is applied on the result side. `done` pulses for one cycle, and `product` stays valid until the next accepted start.

Top module: `smul_shift_add`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all zero.
- R2: A `start` seen at a rising edge while `busy` is low captures `multiplicand`, `multiplier` and `signed_mode`. From the next cycle `busy` is 1, and `product` reads zero in its upper `WIDTH` bits and the captured multiplier in its lower `WIDTH` bits.
- R3: With `signed_mode`=0 captured, the final `product` equals the unsigned product of the two operands, using all `2*WIDTH` bits.
- R4: With `signed_mode`=1 captured, the final `product` equals the two's-complement product of the two operands, using all `2*WIDTH` bits. This includes the most negative value times itself, and all-ones operands (-1).
- R5: `busy` stays high for exactly `WIDTH` cycles after acceptance. `done` rises on the same edge at which `busy` falls, which is the `WIDTH`-th rising edge after the accepting edge.
- R6: `done` is high for exactly one cycle per accepted operation.
- R7: A `start` that arrives while `busy` is high is ignored. It changes neither the result nor the timing of the running operation.
- R8: While idle and without an accepted start, `product` holds its value, whatever happens on the operand and mode inputs.
- R9: Changes on `signed_mode` or on the operand inputs during an operation do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin; accepted when `busy` is low |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| multiplicand | input | WIDTH | First operand |
| multiplier | input | WIDTH | Second operand, consumed bit by bit from the LSB |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Concatenated accumulator and multiplier register |

## Verification
A 5-bit configuration is swept over every pair of operands in both modes, and every result is compared with an arithmetic product computed in the bench. The sweep separates a correct subtraction of the top partial product from plain addition: any negative multiplier gives a different result under each. It also separates sign-filling from zero-filling of the accumulator: any negative multiplicand gives a different result under each. Zero, all-ones and most-negative operands are also run on their own as named cases. Further runs pulse `start`, flip the mode and change the operands while busy, and disturb the inputs while idle. These show that captured values, and not live pins, decide the result, and that the hold and timing rules keep working.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mul_mode_e;

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } step_op_e;

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step_en,
  output logic step_last,
  output logic busy,
  output logic done
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [CW-1:0] step_cnt;

  assign accept    = start && !busy;
  assign step_en   = busy;
  assign step_last = busy && (step_cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      step_cnt <= '0;
    end else begin
      done <= step_last;
      if (accept) begin
        busy     <= 1'b1;
        step_cnt <= '0;
      end else if (step_last) begin
        busy     <= 1'b0;
        step_cnt <= '0;
      end else if (busy) begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/smul_addsub.sv
module smul_addsub
  import smul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] operand,
  input  step_op_e         op,
  input  mul_mode_e        mode,
  output logic [WIDTH:0]   result
);
  logic [WIDTH:0] acc_x;
  logic [WIDTH:0] opd_x;

  always_comb begin
    if (mode == MODE_SIGNED) begin
      acc_x = {acc[WIDTH-1], acc};
      opd_x = {operand[WIDTH-1], operand};
    end else begin
      acc_x = {1'b0, acc};
      opd_x = {1'b0, operand};
    end
    unique case (op)
      OP_ADD:  result = acc_x + opd_x;
      OP_SUB:  result = acc_x - opd_x;
      default: result = acc_x;
    endcase
  end

endmodule

// File: rtl/smul_datapath.sv
module smul_datapath
  import smul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               step_en,
  input  logic               step_last,
  input  logic               signed_mode,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] mplr_q;
  mul_mode_e        mode_q;
  step_op_e         op;
  logic [WIDTH:0]   sum;

  always_comb begin
    if (!mplr_q[0])
      op = OP_PASS;
    else if (step_last && mode_q == MODE_SIGNED)
      op = OP_SUB;
    else
      op = OP_ADD;
  end

  smul_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc     (acc_q),
    .operand (mcand_q),
    .op      (op),
    .mode    (mode_q),
    .result  (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      acc_q   <= '0;
      mplr_q  <= '0;
      mode_q  <= MODE_UNSIGNED;
    end else if (accept) begin
      mcand_q <= multiplicand;
      acc_q   <= '0;
      mplr_q  <= multiplier;
      mode_q  <= signed_mode ? MODE_SIGNED : MODE_UNSIGNED;
    end else if (step_en) begin
      acc_q  <= sum[WIDTH:1];
      mplr_q <= {sum[0], mplr_q[WIDTH-1:1]};
    end
  end

  assign product = {acc_q, mplr_q};

endmodule

// File: rtl/smul_shift_add.sv
module smul_shift_add #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               signed_mode,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic accept;
  logic step_en;
  logic step_last;

  smul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .step_en   (step_en),
    .step_last (step_last),
    .busy      (busy),
    .done      (done)
  );

  smul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .step_en      (step_en),
    .step_last    (step_last),
    .signed_mode  (signed_mode),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );

endmodule

// File: rtl/smul_checker.sv
module smul_checker #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && product[2*WIDTH-1:WIDTH] == '0)); // R2

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < WIDTH)); // R5

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy_run) == WIDTH - 1 && !busy)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> (busy || done)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product)); // R8

endmodule

bind smul_shift_add smul_checker #(.WIDTH(WIDTH)) u_smul_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/smul_shift_add_bench.sv
`timescale 1ns/1ps
module smul_shift_add_bench;
  localparam int W = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           signed_mode = 1'b0;
  logic [W-1:0]   multiplicand = '0;
  logic [W-1:0]   multiplier = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  smul_shift_add #(.WIDTH(W)) u_smul_shift_add (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .signed_mode  (signed_mode),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    int sa;
    int sb;
    sa = int'(a);
    sb = int'(b);
    if (s) begin
      if (a[W-1]) sa = sa - (1 << W);
      if (b[W-1]) sb = sb - (1 << W);
    end
    return (2*W)'(sa * sb);
  endfunction

  // disturb: 0 none, 1 start pulse with other operands mid-run (R7),
  // 2 mode and operands flip mid-run (R9)
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                        input int disturb, input string req);
    logic timing_ok;
    logic [2*W-1:0] exp;
    exp = ref_mul(a, b, s);
    @(negedge clk);
    multiplicand = a;
    multiplier   = b;
    signed_mode  = s;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb == 0) begin
      multiplicand = ~a;
      multiplier   = ~b;
    end
    timing_ok = busy && (product == {{W{1'b0}}, b});
    for (int i = 1; i <= W; i++) begin
      if (i == 2 && disturb == 1) begin
        start = 1'b1;
        multiplicand = a + 1'b1;
        multiplier   = b ^ 5'h15;
      end
      if (i == 2 && disturb == 2) begin
        signed_mode  = ~s;
        multiplicand = a ^ 5'h0a;
        multiplier   = b + 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (i < W) timing_ok = timing_ok && busy && !done;
      else timing_ok = timing_ok && !busy && done;
    end
    check({req, " result"}, 32'(product), 32'(exp));
    check("R2/R5 timing", 32'(timing_ok), 32'd1);
    multiplicand = ~a;
    signed_mode  = ~s;
    @(negedge clk);
    check("R6 done single", 32'(done), 32'd0);
    check("R8 hold", 32'(product), 32'(exp));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 product", 32'(product), 32'd0);
    rst_n = 1'b1;

    // named corners
    run_op(5'h00, 5'h13, 1'b0, 0, "R3 zero");
    run_op(5'h1f, 5'h1f, 1'b0, 0, "R3 all-ones");
    run_op(5'h1f, 5'h1f, 1'b1, 0, "R4 minus-one squared");
    run_op(5'h10, 5'h10, 1'b1, 0, "R4 most-negative squared");
    run_op(5'h10, 5'h0f, 1'b1, 0, "R4 min times max");
    run_op(5'h00, 5'h10, 1'b1, 0, "R4 zero");

    // ignored inputs while busy
    run_op(5'h0b, 5'h17, 1'b1, 1, "R7 start ignored");
    run_op(5'h19, 5'h06, 1'b0, 1, "R7 start ignored");
    run_op(5'h13, 5'h1d, 1'b1, 2, "R9 mode flip");
    run_op(5'h1c, 5'h15, 1'b0, 2, "R9 mode flip");

    // idle disturbance: inputs wander, no start
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      multiplicand = 5'(k * 7);
      multiplier   = 5'(k * 3);
      signed_mode  = k[0];
    end
    @(negedge clk);
    check("R8 idle hold", 32'(product), 32'(ref_mul(5'h1c, 5'h15, 1'b0)));

    // exhaustive sweep both modes
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          run_op(5'(a), 5'(b), s[0], 0, s ? "R4 sweep" : "R3 sweep");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule